// File: doc/BRIEF.md
# Completion Interrupt Coalescer

This block sits beside an instruction-processing queue. It counts finished instructions that asked to be announced by interrupt, and it raises one interrupt line for software. It does not pulse once per completion. The line goes up when enough results have piled up, or when the oldest unacknowledged result has waited long enough. Whichever of the two happens first wins. While nothing is pending, the wait timer sits at zero and the line stays low.

Software reaches the block through a small register bus. The bus sets the count and time thresholds and switches the interrupt on and off through separate set and clear registers. Software acknowledges results by writing the number it has consumed. Each acknowledge subtracts that amount from the pending count and restarts the wait timer. The condition is then re-evaluated from the new state. If results are still outstanding at or above the count threshold, the line comes straight back.

Register offsets on `reg_addr`: 0 pending count (direct write), 1 acknowledge, 2 thresholds, 3 enable set, 4 enable clear. All state is registered. The interrupt output is a combinational function of that state, so any write is reflected on `irq` in the cycle after the clock edge that takes it.

Top module: `cmpl_irq_coalescer`

## Requirements
- R1: A completion pulse with its interrupt-request flag set raises the pending count by one at the next clock edge. A completion with the flag clear leaves the count unchanged.
- R2: Writing N to offset 1 subtracts N from the pending count. A request-flagged completion in the same cycle gives count + 1 − N. A result below zero saturates at zero. Reading offset 0 or 1 returns the pending count in bits 19:0.
- R3: While the pending count is zero, the wait timer is held at zero and `irq` is low.
- R4: With a nonzero count, the timer advances once per cycle. The interrupt condition holds when the count is at least the count threshold, or when the timer is at least the time threshold × 1024 cycles. With time threshold 1, `irq` rises exactly 1024 cycles after the count became nonzero.
- R5: A time threshold of 0 disables time-based firing. A count threshold of 0 acts as 1.
- R6: A write to offset 0 or offset 1, including an acknowledge of 0, restarts the timer at zero. `irq` in the next cycle reflects the new count against the count threshold, so it stays or comes back high when results remain at or above it.
- R7: With the enable clear, `irq` stays low, while counting and timing proceed unchanged. Setting the enable again exposes the current condition at once.
- R8: Writing a value with bit 0 set to offset 3 sets the enable, and to offset 4 clears it. Writing 0 to either has no effect. Both offsets read the enable in bit 0.
- R9: Offset 2 holds the count threshold in bits 19:0 and the time threshold in bits 47:32. It reads back with all other bits zero.
- R10: The pending count holds at 0xFFFFF instead of wrapping when incremented, and the timer holds at its maximum value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmpl_valid | input | 1 | One-cycle pulse per finished instruction |
| cmpl_want_irq | input | 1 | Finished instruction asked for a completion interrupt |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset for read and write |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for `reg_addr` (combinational) |
| irq | output | 1 | Coalesced completion interrupt |

## Verification
On every cycle, the bound checker enforces the following:
- An unflagged completion does not move the count.
- An acknowledge never raises it.
- The timer stays at zero while nothing is pending and restarts on an acknowledge.
- The timer never wraps from its ceiling.
- `irq` is low whenever the enable is clear.
- The enable follows set and clear writes.

Other behaviours involve chosen thresholds and long waits, so only the bench scenarios show them:
- the exact 1024-cycle firing point;
- the disabled time threshold;
- a zero count threshold acting as one;
- the combined completion-plus-acknowledge arithmetic;
- immediate re-assertion after a partial acknowledge;
- the field layout of the threshold register.

// File: rtl/coal_pkg.sv
package coal_pkg;

  localparam int COAL_AW = 3;

  typedef enum logic [COAL_AW-1:0] {
    REG_COUNT   = 3'd0,
    REG_ACK     = 3'd1,
    REG_WAIT    = 3'd2,
    REG_ENA_SET = 3'd3,
    REG_ENA_CLR = 3'd4
  } coal_reg_e;

  // Pending count after one cycle: add the completion, remove the
  // acknowledged amount, clamp into [0, top_val].
  function automatic logic [31:0] count_next(input logic [31:0] cur,
                                             input logic        inc,
                                             input logic [31:0] dec,
                                             input logic [31:0] top_val);
    logic [32:0] up;
    up = {1'b0, cur} + {32'd0, inc};
    if ({1'b0, dec} >= up) return 32'd0;
    up = up - {1'b0, dec};
    if (up > {1'b0, top_val}) return top_val;
    return up[31:0];
  endfunction

  // Timer after one cycle: cleared on hold, else climbs to a ceiling.
  function automatic logic [31:0] timer_next(input logic [31:0] cur,
                                             input logic        hold,
                                             input logic [31:0] top_val);
    if (hold) return 32'd0;
    if (cur >= top_val) return top_val;
    return cur + 32'd1;
  endfunction

  // Interrupt condition from pending count, timer and thresholds.
  function automatic logic coalesce_due(input logic [31:0] cnt,
                                        input logic [31:0] tmr,
                                        input logic [31:0] nw,
                                        input logic [31:0] tw_cycles,
                                        input logic        tw_on);
    logic [31:0] nw_eff;
    nw_eff = (nw == 32'd0) ? 32'd1 : nw;
    if (cnt == 32'd0) return 1'b0;
    return (cnt >= nw_eff) || (tw_on && (tmr >= tw_cycles));
  endfunction

endpackage

// File: rtl/coal_regif.sv
module coal_regif
  import coal_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int CNT_W  = 20,
  parameter int TW_W   = 16,
  parameter int TW_LSB = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr_en,
  input  logic [COAL_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  input  logic [CNT_W-1:0]   cnt_q,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               ack_wr,
  output logic               cnt_wr,
  output logic               ena_set_wr,
  output logic               ena_clr_wr,
  output logic [CNT_W-1:0]   wr_cnt_field,
  output logic [CNT_W-1:0]   num_wait,
  output logic [TW_W-1:0]    time_wait,
  output logic               ena_q
);

  coal_reg_e sel;
  logic      wait_wr;
  logic      unused_wdata_bits;

  assign sel          = coal_reg_e'(reg_addr);
  assign ack_wr       = reg_wr_en && (sel == REG_ACK);
  assign cnt_wr       = reg_wr_en && (sel == REG_COUNT);
  assign wait_wr      = reg_wr_en && (sel == REG_WAIT);
  assign ena_set_wr   = reg_wr_en && (sel == REG_ENA_SET) && reg_wdata[0];
  assign ena_clr_wr   = reg_wr_en && (sel == REG_ENA_CLR) && reg_wdata[0];
  assign wr_cnt_field = reg_wdata[CNT_W-1:0];

  assign unused_wdata_bits = ^{reg_wdata[DATA_W-1:TW_LSB+TW_W],
                               reg_wdata[TW_LSB-1:CNT_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      num_wait  <= '0;
      time_wait <= '0;
    end else if (wait_wr) begin
      num_wait  <= reg_wdata[CNT_W-1:0];
      time_wait <= reg_wdata[TW_LSB +: TW_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ena_q <= 1'b0;
    else if (ena_set_wr) ena_q <= 1'b1;
    else if (ena_clr_wr) ena_q <= 1'b0;
  end

  always_comb begin
    reg_rdata = '0;
    case (sel)
      REG_COUNT, REG_ACK: reg_rdata[CNT_W-1:0] = cnt_q;
      REG_WAIT: begin
        reg_rdata[CNT_W-1:0]       = num_wait;
        reg_rdata[TW_LSB +: TW_W]  = time_wait;
      end
      REG_ENA_SET, REG_ENA_CLR: reg_rdata[0] = ena_q;
      default: reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/coal_done_ctr.sv
module coal_done_ctr
  import coal_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             ack_wr,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] wr_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             cnt_zero
);

  localparam logic [31:0] CNT_MAX = (32'd1 << CNT_W) - 32'd1;

  logic [31:0]      dec;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    dec = ack_wr ? 32'(wr_val) : 32'd0;
    if (cnt_wr) cnt_d = wr_val;
    else        cnt_d = CNT_W'(count_next(32'(cnt_q), inc, dec, CNT_MAX));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_zero = (cnt_q == '0);

endmodule

// File: rtl/coal_timer.sv
module coal_timer
  import coal_pkg::*;
#(
  parameter int TMR_W = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             idle,
  output logic [TMR_W-1:0] tmr_q
);

  localparam logic [31:0] TMR_MAX = (32'd1 << TMR_W) - 32'd1;

  logic [TMR_W-1:0] tmr_d;

  assign tmr_d = TMR_W'(timer_next(32'(tmr_q), restart || idle, TMR_MAX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr_q <= '0;
    else        tmr_q <= tmr_d;
  end

endmodule

// File: rtl/cmpl_irq_coalescer.sv
module cmpl_irq_coalescer
  import coal_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int CNT_W     = 20,
  parameter int TW_W      = 16,
  parameter int TW_LSB    = 32,
  parameter int UNIT_LOG2 = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmpl_valid,
  input  logic               cmpl_want_irq,
  input  logic               reg_wr_en,
  input  logic [COAL_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               irq
);

  localparam int TMR_W = TW_W + UNIT_LOG2;

  logic             ack_wr, cnt_wr, ena_set_wr, ena_clr_wr, ena_q;
  logic             cnt_zero, cmpl_inc, cond;
  logic [CNT_W-1:0] wr_cnt_field, num_wait, cnt_q;
  logic [TW_W-1:0]  time_wait;
  logic [TMR_W-1:0] tmr_q;
  logic [31:0]      tw_cycles;

  assign cmpl_inc = cmpl_valid && cmpl_want_irq;

  coal_regif #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .TW_W(TW_W), .TW_LSB(TW_LSB)
  ) u_regif (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .cnt_q(cnt_q), .reg_rdata(reg_rdata),
    .ack_wr(ack_wr), .cnt_wr(cnt_wr),
    .ena_set_wr(ena_set_wr), .ena_clr_wr(ena_clr_wr),
    .wr_cnt_field(wr_cnt_field), .num_wait(num_wait),
    .time_wait(time_wait), .ena_q(ena_q)
  );

  coal_done_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .inc(cmpl_inc),
    .ack_wr(ack_wr), .cnt_wr(cnt_wr), .wr_val(wr_cnt_field),
    .cnt_q(cnt_q), .cnt_zero(cnt_zero)
  );

  coal_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_n),
    .restart(ack_wr || cnt_wr), .idle(cnt_zero),
    .tmr_q(tmr_q)
  );

  assign tw_cycles = 32'(time_wait) << UNIT_LOG2;
  assign cond = coalesce_due(32'(cnt_q), 32'(tmr_q), 32'(num_wait),
                             tw_cycles, time_wait != '0);
  assign irq  = ena_q && cond;

endmodule

// File: rtl/coal_chk.sv
module coal_chk #(
  parameter int CNT_W = 20,
  parameter int TMR_W = 26
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmpl_valid,
  input logic             cmpl_want_irq,
  input logic             irq,
  input logic [CNT_W-1:0] cnt_q,
  input logic [TMR_W-1:0] tmr_q,
  input logic             ena_q,
  input logic             ack_wr,
  input logic             cnt_wr,
  input logic             ena_set_wr,
  input logic             ena_clr_wr
);

  // R1
  unflagged_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_valid && !cmpl_want_irq && !ack_wr && !cnt_wr) |=> $stable(cnt_q));

  // R2
  ack_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && !cmpl_valid) |=> (cnt_q <= $past(cnt_q)));

  // R3
  idle_timer_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0) |=> (tmr_q == '0));

  // R6
  restart_timer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr || cnt_wr) |=> (tmr_q == '0));

  // R7
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ena_q |-> !irq);

  // R8
  ena_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ena_set_wr |=> ena_q);

  // R8
  ena_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ena_clr_wr |=> !ena_q);

  // R10
  timer_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&tmr_q) |=> ((&tmr_q) || (tmr_q == '0)));

endmodule

bind cmpl_irq_coalescer coal_chk #(.CNT_W(CNT_W), .TMR_W(TMR_W)) i_chk (
  .clk(clk), .rst_n(rst_n),
  .cmpl_valid(cmpl_valid), .cmpl_want_irq(cmpl_want_irq), .irq(irq),
  .cnt_q(cnt_q), .tmr_q(tmr_q), .ena_q(ena_q),
  .ack_wr(ack_wr), .cnt_wr(cnt_wr),
  .ena_set_wr(ena_set_wr), .ena_clr_wr(ena_clr_wr)
);

// File: tb/test_cmpl_irq_coalescer.sv
module test_cmpl_irq_coalescer;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmpl_valid, cmpl_want_irq, reg_wr_en;
  logic [2:0]  reg_addr;
  logic [63:0] reg_wdata, reg_rdata;
  logic        irq;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  cmpl_irq_coalescer i_cmpl_irq_coalescer (
    .clk(clk), .rst_n(rst_n),
    .cmpl_valid(cmpl_valid), .cmpl_want_irq(cmpl_want_irq),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  typedef struct packed {
    logic        c;
    logic        w;
    logic        wr;
    logic [2:0]  a;
    logic [63:0] d;
    logic [19:0] cnt;
    logic        irq;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,1'b1,3'd2,64'd3,     20'd0,1'b0,4'd9},  // R9 count threshold 3
    '{1'b0,1'b0,1'b1,3'd3,64'd1,     20'd0,1'b0,4'd3},  // R3 enabled, nothing pending
    '{1'b1,1'b1,1'b0,3'd0,64'd0,     20'd1,1'b0,4'd1},  // R1
    '{1'b1,1'b0,1'b0,3'd0,64'd0,     20'd1,1'b0,4'd1},  // R1 unflagged ignored
    '{1'b1,1'b1,1'b0,3'd0,64'd0,     20'd2,1'b0,4'd1},  // R1
    '{1'b1,1'b1,1'b0,3'd0,64'd0,     20'd3,1'b1,4'd4},  // R4 count reaches 3
    '{1'b0,1'b0,1'b1,3'd1,64'd1,     20'd2,1'b0,4'd2},  // R2 ack 1
    '{1'b1,1'b1,1'b1,3'd1,64'd2,     20'd1,1'b0,4'd2},  // R2 2+1-2
    '{1'b0,1'b0,1'b1,3'd1,64'd5,     20'd0,1'b0,4'd2},  // R2 saturate at 0
    '{1'b0,1'b0,1'b1,3'd0,64'd4,     20'd4,1'b1,4'd6},  // R6 direct write
    '{1'b0,1'b0,1'b1,3'd4,64'd0,     20'd4,1'b1,4'd8},  // R8 clear with 0: no effect
    '{1'b0,1'b0,1'b1,3'd4,64'd1,     20'd4,1'b0,4'd7},  // R7 disabled
    '{1'b1,1'b1,1'b0,3'd0,64'd0,     20'd5,1'b0,4'd7},  // R7 still counts
    '{1'b0,1'b0,1'b1,3'd3,64'd0,     20'd5,1'b0,4'd8},  // R8 set with 0: no effect
    '{1'b0,1'b0,1'b1,3'd3,64'd1,     20'd5,1'b1,4'd7},  // R7 re-enabled
    '{1'b0,1'b0,1'b1,3'd2,64'd0,     20'd5,1'b1,4'd5},  // R5 threshold 0 acts as 1
    '{1'b0,1'b0,1'b1,3'd1,64'd5,     20'd0,1'b0,4'd3},  // R3 drained
    '{1'b0,1'b0,1'b1,3'd2,64'd2,     20'd0,1'b0,4'd9},  // R9 count threshold 2
    '{1'b1,1'b1,1'b0,3'd0,64'd0,     20'd1,1'b0,4'd4},  // R4 below
    '{1'b1,1'b1,1'b0,3'd0,64'd0,     20'd2,1'b1,4'd4},  // R4 at threshold
    '{1'b1,1'b1,1'b0,3'd0,64'd0,     20'd3,1'b1,4'd4},  // R4 above
    '{1'b0,1'b0,1'b1,3'd1,64'd1,     20'd2,1'b1,4'd6},  // R6 re-asserts at once
    '{1'b0,1'b0,1'b1,3'd1,64'd2,     20'd0,1'b0,4'd2}   // R2 full ack
  };

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle_in();
    cmpl_valid = 1'b0; cmpl_want_irq = 1'b0; reg_wr_en = 1'b0;
    reg_addr = 3'd0; reg_wdata = '0;
  endtask

  // Called at a falling edge; inputs held through one rising edge.
  task automatic apply(input logic c, input logic w, input logic wr,
                       input logic [2:0] a, input logic [63:0] d);
    cmpl_valid = c; cmpl_want_irq = w; reg_wr_en = wr;
    reg_addr = a; reg_wdata = d;
    @(negedge clk);
    idle_in();
  endtask

  task automatic rd(input logic [2:0] a, output logic [63:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
    reg_addr = 3'd0;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [63:0] v;
    idle_in();
    rst_n = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // Reset state (R3, R8, R9)
    rd(3'd0, v); chk("R3", "reset count", v, 64'd0);
    chk("R3", "reset irq", 64'(irq), 64'd0);
    rd(3'd3, v); chk("R8", "reset enable", v, 64'd0);
    rd(3'd2, v); chk("R9", "reset thresholds", v, 64'd0);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i].c, VEC[i].w, VEC[i].wr, VEC[i].a, VEC[i].d);
      rd(3'd0, v);
      chk($sformatf("R%0d", VEC[i].req), $sformatf("vec %0d count", i),
          v, 64'(VEC[i].cnt));
      chk($sformatf("R%0d", VEC[i].req), $sformatf("vec %0d irq", i),
          64'(irq), 64'(VEC[i].irq));
    end

    // R2: acknowledge offset reads the count
    apply(1'b1, 1'b1, 1'b0, 3'd0, 64'd0);
    rd(3'd1, v); chk("R2", "ack readback", v, 64'd1);
    apply(1'b0, 1'b0, 1'b1, 3'd1, 64'd1);

    // R4: time threshold 1, count threshold 100
    apply(1'b0, 1'b0, 1'b1, 3'd2, (64'd1 << 32) | 64'd100);
    apply(1'b1, 1'b1, 1'b0, 3'd0, 64'd0);
    tick(1023);
    chk("R4", "timer 1023 irq", 64'(irq), 64'd0);
    tick(1);
    chk("R4", "timer 1024 irq", 64'(irq), 64'd1);

    // R6: zero acknowledge restarts the timer
    apply(1'b0, 1'b0, 1'b1, 3'd1, 64'd0);
    chk("R6", "after restart irq", 64'(irq), 64'd0);
    rd(3'd0, v); chk("R6", "count kept", v, 64'd1);
    tick(1023);
    chk("R6", "restart 1023 irq", 64'(irq), 64'd0);
    tick(1);
    chk("R6", "restart 1024 irq", 64'(irq), 64'd1);
    apply(1'b0, 1'b0, 1'b1, 3'd1, 64'd1);
    chk("R3", "drained irq", 64'(irq), 64'd0);

    // R5: time threshold 0 never fires on time
    apply(1'b0, 1'b0, 1'b1, 3'd2, 64'd100);
    apply(1'b1, 1'b1, 1'b0, 3'd0, 64'd0);
    tick(1100);
    chk("R5", "time disabled irq", 64'(irq), 64'd0);
    apply(1'b0, 1'b0, 1'b1, 3'd1, 64'd1);

    // R10: count holds at its maximum
    apply(1'b0, 1'b0, 1'b1, 3'd0, 64'hFFFFF);
    apply(1'b1, 1'b1, 1'b0, 3'd0, 64'd0);
    rd(3'd0, v); chk("R10", "count ceiling", v, 64'hFFFFF);
    apply(1'b0, 1'b0, 1'b1, 3'd0, 64'd0);

    // R9: field layout
    apply(1'b0, 1'b0, 1'b1, 3'd2, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(3'd2, v); chk("R9", "threshold layout", v, 64'h0000_FFFF_000F_FFFF);

    // R8: enable reads at both offsets
    rd(3'd3, v); chk("R8", "enable via set", v, 64'd1);
    rd(3'd4, v); chk("R8", "enable via clear", v, 64'd1);
    apply(1'b0, 1'b0, 1'b1, 3'd4, 64'd1);
    rd(3'd3, v); chk("R8", "cleared via set", v, 64'd0);
    rd(3'd4, v); chk("R8", "cleared via clear", v, 64'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule